// File: doc/BRIEF.md
# Integer Decode and Execute Stage with Register File

This block decodes one 32-bit instruction word from a small fixed-format integer instruction subset and executes it. The instruction's source fields index a 32-entry by 32-bit register file through two asynchronous read ports. A combinational arithmetic and logic unit produces the result, the destination index and a write strobe in the same cycle. The result is stored into the register file on the next rising clock edge, so a stream of instructions presented one per cycle runs as a tiny single-cycle datapath.

The instruction word has three fields in common: the operation code in bits 31:26, the first source index in bits 25:21 and the second source index in bits 20:16. Register-register operations (operation code 0) name their destination in bits 15:11, a shift distance in bits 10:6 and a function selector in bits 5:0. Immediate operations replace bits 15:0 with a 16-bit constant and write the register named by bits 20:16. Entry 0 of the register file is a constant zero. A word that matches no supported operation raises an illegal flag and writes nothing.

Top module: `iexu_top`

## Requirements
- R1: With operation code 0, the destination is bits 15:11; function 0x20 writes the sum of the two sources, so word 0x00622020 drives destination 4 with register 3 plus register 2.
- R2: Function 0x22 writes first source minus second, 0x24 the bitwise AND, 0x25 the bitwise OR, and 0x27 the inverse of the OR; the last with register 0 as second source inverts the first source.
- R3: Function 0x00 shifts the second source left by the count in bits 10:6; word 0x000519C0 writes register 5 shifted left by 7 into destination 3.
- R4: Function 0x2A writes 1 when the first source is less than the second as signed numbers and 0 otherwise; function 0x2B does the same with an unsigned comparison (0xFFFFFFFF against 1 gives 1 and 0 respectively).
- R5: Operation codes 0x08 (add), 0x0A (signed less-than) and 0x0B (unsigned less-than) copy bit 15 of the constant into bits 31:16 before use, and write the register named by bits 20:16.
- R6: Operation codes 0x0C (AND) and 0x0D (OR) fill bits 31:16 of the constant with zeros.
- R7: Operation code 0x0F writes the constant into bits 31:16 and zeros into bits 15:0; a following 0x0D operation on the same register completes a full 32-bit constant.
- R8: Register 0 reads as zero, and an instruction whose destination is register 0 keeps the write strobe low and leaves the register file unchanged.
- R9: An unsupported operation code, or an unsupported function under operation code 0, raises the illegal flag, keeps the write strobe low and changes no register.
- R10: A result is stored at the rising edge that ends its cycle; an instruction that reads its own destination sees the old value, and the next instruction sees the new one. Reset clears every register to zero.
- R11: While the valid input is low the write strobe and illegal flag stay low and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the register file |
| instr_valid | input | 1 | The instruction word is to be executed this cycle |
| instr | input | 32 | Instruction word |
| rd_idx | output | 5 | Destination register index of the current instruction |
| wr_en | output | 1 | The result is stored into rd_idx at the next rising edge |
| result | output | 32 | Computed result of the current instruction |
| illegal | output | 1 | The valid instruction is not a supported operation |

## Verification
The two functions that coincide are the read of a source register and the write-back into that same register: an instruction that names one register as both source and destination reads it while its own result is about to be stored there. The bench provokes this by decrementing a register in place and by filling a register's low half with an OR after loading its upper half, then judges that the result shown in the cycle uses the old contents and that the next instruction reading the register sees the new one. Writes aimed at register 0, illegal words and idle cycles are each followed by a read of the register they might have changed.

// File: rtl/iexu_pkg.sv
`timescale 1ns/1ps
package iexu_pkg;

    localparam int XLEN    = 32;
    localparam int IDX_W   = 5;
    localparam int NREG    = 2 ** IDX_W;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int SHAMT_W = 5;
    localparam int IMM_W   = 16;
    localparam int EXT_W   = XLEN - IMM_W;

    // operation codes
    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

    // function selectors under OPC_REG
    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
    localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_NOR,
        ALU_SHL,
        ALU_LTS,
        ALU_LTU,
        ALU_PASSB
    } alu_op_e;

    typedef struct packed {
        alu_op_e          op;
        logic             use_imm;
        logic [XLEN-1:0]  imm_val;
        logic [IDX_W-1:0] dest;
        logic             legal;
    } dec_t;

endpackage

// File: rtl/iexu_decode.sv
`timescale 1ns/1ps
module iexu_decode
    import iexu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [FN_W-1:0]  funct_i,
    input  logic [IDX_W-1:0] rt_i,
    input  logic [IDX_W-1:0] rd_i,
    input  logic [IMM_W-1:0] imm_i,
    output dec_t             dec_o
);

    dec_t            dec_d;
    logic [XLEN-1:0] imm_sext;
    logic [XLEN-1:0] imm_zext;
    logic [XLEN-1:0] imm_upper;

    always_comb begin
        imm_sext  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        imm_zext  = {{EXT_W{1'b0}}, imm_i};
        imm_upper = {imm_i, {EXT_W{1'b0}}};

        dec_d.op      = ALU_ADD;
        dec_d.use_imm = 1'b0;
        dec_d.imm_val = '0;
        dec_d.dest    = rd_i;
        dec_d.legal   = 1'b1;

        unique case (opcode_i)
            OPC_REG: begin
                unique case (funct_i)
                    FN_SLL:  dec_d.op = ALU_SHL;
                    FN_ADD:  dec_d.op = ALU_ADD;
                    FN_SUB:  dec_d.op = ALU_SUB;
                    FN_AND:  dec_d.op = ALU_AND;
                    FN_OR:   dec_d.op = ALU_OR;
                    FN_NOR:  dec_d.op = ALU_NOR;
                    FN_SLT:  dec_d.op = ALU_LTS;
                    FN_SLTU: dec_d.op = ALU_LTU;
                    default: dec_d.legal = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                dec_d.op      = ALU_ADD;
                dec_d.use_imm = 1'b1;
                dec_d.imm_val = imm_sext;
                dec_d.dest    = rt_i;
            end
            OPC_SLTI: begin
                dec_d.op      = ALU_LTS;
                dec_d.use_imm = 1'b1;
                dec_d.imm_val = imm_sext;
                dec_d.dest    = rt_i;
            end
            OPC_SLTIU: begin
                dec_d.op      = ALU_LTU;
                dec_d.use_imm = 1'b1;
                dec_d.imm_val = imm_sext;
                dec_d.dest    = rt_i;
            end
            OPC_ANDI: begin
                dec_d.op      = ALU_AND;
                dec_d.use_imm = 1'b1;
                dec_d.imm_val = imm_zext;
                dec_d.dest    = rt_i;
            end
            OPC_ORI: begin
                dec_d.op      = ALU_OR;
                dec_d.use_imm = 1'b1;
                dec_d.imm_val = imm_zext;
                dec_d.dest    = rt_i;
            end
            OPC_LUI: begin
                dec_d.op      = ALU_PASSB;
                dec_d.use_imm = 1'b1;
                dec_d.imm_val = imm_upper;
                dec_d.dest    = rt_i;
            end
            default: begin
                dec_d.legal = 1'b0;
                dec_d.dest  = rt_i;
            end
        endcase
    end

    assign dec_o = dec_d;

endmodule

// File: rtl/iexu_alu.sv
`timescale 1ns/1ps
module iexu_alu
    import iexu_pkg::*;
(
    input  alu_op_e            op_i,
    input  logic [XLEN-1:0]    a_i,
    input  logic [XLEN-1:0]    b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [XLEN-1:0]    y_o
);

    logic            lt_signed;
    logic            lt_unsigned;
    logic [XLEN-1:0] y_d;

    always_comb begin
        lt_signed   = $signed(a_i) < $signed(b_i);
        lt_unsigned = a_i < b_i;
        unique case (op_i)
            ALU_ADD:   y_d = a_i + b_i;
            ALU_SUB:   y_d = a_i - b_i;
            ALU_AND:   y_d = a_i & b_i;
            ALU_OR:    y_d = a_i | b_i;
            ALU_NOR:   y_d = ~(a_i | b_i);
            ALU_SHL:   y_d = b_i << shamt_i;
            ALU_LTS:   y_d = {{(XLEN-1){1'b0}}, lt_signed};
            ALU_LTU:   y_d = {{(XLEN-1){1'b0}}, lt_unsigned};
            ALU_PASSB: y_d = b_i;
            default:   y_d = '0;
        endcase
    end

    assign y_o = y_d;

endmodule

// File: rtl/iexu_regfile.sv
`timescale 1ns/1ps
module iexu_regfile #(
    parameter  int W      = 32,
    parameter  int NREG   = 32,
    parameter  int RPORTS = 2,
    localparam int AW     = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [RPORTS-1:0][AW-1:0]  raddr_i,
    output logic [RPORTS-1:0][W-1:0]   rdata_o,
    input  logic                       we_i,
    input  logic [AW-1:0]              waddr_i,
    input  logic [W-1:0]               wdata_i
);

    typedef struct packed {
        logic [NREG-1:0][W-1:0] regs;
    } rf_state_t;

    rf_state_t state_d;
    rf_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (we_i) begin
            state_d.regs[waddr_i] = wdata_i;
        end
        state_d.regs[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar g = 0; g < RPORTS; g++) begin : g_rport
        assign rdata_o[g] = (raddr_i[g] == '0) ? '0 : state_q.regs[raddr_i[g]];
    end

endmodule

// File: rtl/iexu_top.sv
`timescale 1ns/1ps
module iexu_top
    import iexu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [XLEN-1:0]  instr,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [XLEN-1:0]  result,
    output logic             illegal
);

    localparam int RPORTS = 2;

    logic [OPC_W-1:0]   f_opcode;
    logic [IDX_W-1:0]   f_rs;
    logic [IDX_W-1:0]   f_rt;
    logic [IDX_W-1:0]   f_rd;
    logic [SHAMT_W-1:0] f_shamt;
    logic [FN_W-1:0]    f_funct;
    logic [IMM_W-1:0]   f_imm;

    assign f_opcode = instr[31:26];
    assign f_rs     = instr[25:21];
    assign f_rt     = instr[20:16];
    assign f_rd     = instr[15:11];
    assign f_shamt  = instr[10:6];
    assign f_funct  = instr[5:0];
    assign f_imm    = instr[15:0];

    dec_t                         dec;
    logic [RPORTS-1:0][IDX_W-1:0] rf_raddr;
    logic [RPORTS-1:0][XLEN-1:0]  rf_rdata;
    logic [XLEN-1:0]              opnd_b;
    logic [XLEN-1:0]              alu_y;
    logic                         commit;

    iexu_decode u_decode (
        .opcode_i (f_opcode),
        .funct_i  (f_funct),
        .rt_i     (f_rt),
        .rd_i     (f_rd),
        .imm_i    (f_imm),
        .dec_o    (dec)
    );

    assign rf_raddr[0] = f_rs;
    assign rf_raddr[1] = f_rt;

    iexu_regfile #(
        .W      (XLEN),
        .NREG   (NREG),
        .RPORTS (RPORTS)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_i (rf_raddr),
        .rdata_o (rf_rdata),
        .we_i    (commit),
        .waddr_i (dec.dest),
        .wdata_i (alu_y)
    );

    assign opnd_b = dec.use_imm ? dec.imm_val : rf_rdata[1];

    iexu_alu u_alu (
        .op_i    (dec.op),
        .a_i     (rf_rdata[0]),
        .b_i     (opnd_b),
        .shamt_i (f_shamt),
        .y_o     (alu_y)
    );

    assign commit  = instr_valid && dec.legal && (dec.dest != '0);
    assign wr_en   = commit;
    assign illegal = instr_valid && !dec.legal;
    assign rd_idx  = dec.dest;
    assign result  = alu_y;

endmodule

// File: rtl/iexu_chk.sv
`timescale 1ns/1ps
module iexu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [31:0] instr,
    input logic [4:0]  rd_idx,
    input logic        wr_en,
    input logic [31:0] result,
    input logic        illegal
);

    logic is_cmp;
    logic unused_fields;

    assign unused_fields = ^{instr[25:21], instr[10:6]};
    assign is_cmp = ((instr[31:26] == 6'h00) && ((instr[5:0] == 6'h2A) || (instr[5:0] == 6'h2B)))
                 || (instr[31:26] == 6'h0A) || (instr[31:26] == 6'h0B);

    p_illegal_blocks_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en);

    p_zero_dest_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rd_idx != 5'd0));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (!wr_en && !illegal));

    p_upper_imm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[31:26] == 6'h0F) |-> (result == {instr[15:0], 16'h0000}));

    p_compare_bool_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_cmp) |-> (result[31:1] == 31'd0));

    p_reg_dest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && instr[31:26] == 6'h00) |-> (rd_idx == instr[15:11]));

    p_imm_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && instr[31:26] != 6'h00) |-> (rd_idx == instr[20:16]));

endmodule

bind iexu_top iexu_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .rd_idx      (rd_idx),
    .wr_en       (wr_en),
    .result      (result),
    .illegal     (illegal)
);

// File: tb/iexu_top_test.sv
`timescale 1ns/1ps
module iexu_top_test;

    logic        clk;
    logic        rst_n;
    logic        instr_valid;
    logic [31:0] instr;
    logic [4:0]  rd_idx;
    logic        wr_en;
    logic [31:0] result;
    logic        illegal;

    iexu_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .rd_idx      (rd_idx),
        .wr_en       (wr_en),
        .result      (result),
        .illegal     (illegal)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    typedef struct {
        logic [4:0]  rd;
        logic        wen;
        logic        ill;
        logic [31:0] res;
        bit          chk_data;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    function automatic logic [31:0] rty(input int rs, input int rt, input int rd,
                                        input int sh, input logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
    endfunction

    function automatic logic [31:0] ity(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    task automatic issue(input logic v, input logic [31:0] ins, input logic [4:0] erd,
                         input logic ewen, input logic eill, input logic [31:0] eres,
                         input bit cd, input string tag);
        exp_t e;
        @(negedge clk);
        instr_valid = v;
        instr       = ins;
        e.rd = erd; e.wen = ewen; e.ill = eill; e.res = eres; e.chk_data = cd; e.tag = tag;
        expq.push_back(e);
    endtask

    // write-producing instruction with data check
    task automatic wr(input logic [31:0] ins, input int erd, input logic [31:0] eres,
                      input string tag);
        issue(1'b1, ins, erd[4:0], 1'b1, 1'b0, eres, 1'b1, tag);
    endtask

    // monitor: sample 1.5 ns after the falling edge, before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (expq.size() > 0) begin
                exp_t e;
                bit bad;
                e = expq.pop_front();
                bad = (wr_en !== e.wen) || (illegal !== e.ill);
                if (e.chk_data) bad = bad || (rd_idx !== e.rd) || (result !== e.res);
                n_checks++;
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: got wen=%0b ill=%0b rd=%0d res=%h expected wen=%0b ill=%0b rd=%0d res=%h",
                             e.tag, wr_en, illegal, rd_idx, result, e.wen, e.ill, e.rd, e.res);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        instr_valid = 1'b0;
        instr       = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 and R10: idle after reset, registers cleared
        issue(1'b0, rty(3, 2, 4, 0, 6'h20), 5'd4, 1'b0, 1'b0, 32'h0, 1'b0, "R11 idle after reset");
        wr(rty(7, 0, 1, 0, 6'h25), 1, 32'h0, "R10 reset clears r7");
        wr(rty(31, 0, 1, 0, 6'h25), 1, 32'h0, "R10 reset clears r31");

        // R7: upper load then low fill; R10 same-cycle read of own destination
        wr(ity(6'h0F, 0, 3, 16'h1234), 3, 32'h1234_0000, "R7 upper load");
        wr(ity(6'h0D, 3, 3, 16'h5678), 3, 32'h1234_5678, "R7 low fill after upper load");
        wr(ity(6'h08, 0, 2, 16'h0005), 2, 32'h0000_0005, "R5 addi positive");

        // R1: the given add word
        wr(32'h0062_2020, 4, 32'h1234_567D, "R1 add word 0x00622020");
        wr(ity(6'h08, 4, 4, 16'hFFFF), 4, 32'h1234_567C, "R10 in-place decrement sees old value");
        wr(rty(4, 0, 6, 0, 6'h25), 6, 32'h1234_567C, "R10 next read sees written value");

        // R3: the given shift word
        wr(ity(6'h08, 0, 5, 16'h0003), 5, 32'h0000_0003, "R5 addi small");
        wr(32'h0005_19C0, 3, 32'h0000_0180, "R3 shift word 0x000519C0");

        // R2
        wr(rty(2, 0, 7, 0, 6'h27), 7, 32'hFFFF_FFFA, "R2 nor with r0 inverts");
        wr(rty(2, 5, 8, 0, 6'h22), 8, 32'h0000_0002, "R2 sub");
        wr(rty(5, 2, 8, 0, 6'h22), 8, 32'hFFFF_FFFE, "R2 sub negative");
        wr(rty(3, 7, 9, 0, 6'h24), 9, 32'h0000_0180, "R2 and");
        wr(rty(2, 5, 10, 0, 6'h25), 10, 32'h0000_0007, "R2 or");
        wr(rty(2, 5, 10, 0, 6'h27), 10, 32'hFFFF_FFF8, "R2 nor two registers");

        // R4
        wr(ity(6'h08, 0, 11, 16'hFFFF), 11, 32'hFFFF_FFFF, "R5 addi negative one");
        wr(ity(6'h08, 0, 12, 16'h0001), 12, 32'h0000_0001, "R5 addi one");
        wr(rty(11, 12, 13, 0, 6'h2A), 13, 32'h1, "R4 signed less-than true");
        wr(rty(11, 12, 14, 0, 6'h2B), 14, 32'h0, "R4 unsigned less-than false");
        wr(rty(12, 11, 14, 0, 6'h2B), 14, 32'h1, "R4 unsigned less-than true");

        // R5: sign-extended compares
        wr(ity(6'h0A, 11, 15, 16'hFFFE), 15, 32'h0, "R5 slti -1 vs -2");
        wr(ity(6'h0A, 11, 15, 16'h0000), 15, 32'h1, "R5 slti -1 vs 0");
        wr(ity(6'h0B, 12, 16, 16'hFFFF), 16, 32'h1, "R5 sltiu extends then unsigned");

        // R6: zero-extended logic immediates
        wr(ity(6'h0C, 11, 17, 16'h8001), 17, 32'h0000_8001, "R6 andi zero-extend");
        wr(ity(6'h0D, 0, 18, 16'hF000), 18, 32'h0000_F000, "R6 ori zero-extend");

        // R8: register 0
        issue(1'b1, ity(6'h08, 0, 0, 16'h0007), 5'd0, 1'b0, 1'b0, 32'h7, 1'b1, "R8 write to r0 strobe low");
        wr(rty(0, 0, 1, 0, 6'h25), 1, 32'h0, "R8 r0 still zero");
        wr(rty(0, 11, 1, 0, 6'h20), 1, 32'hFFFF_FFFF, "R8 r0 reads zero as source");

        // R9: illegal words leave registers unchanged
        issue(1'b1, ity(6'h3F, 0, 2, 16'h1234), 5'd2, 1'b0, 1'b1, 32'h0, 1'b0, "R9 bad operation code");
        wr(rty(2, 0, 1, 0, 6'h25), 1, 32'h5, "R9 r2 kept after bad operation code");
        issue(1'b1, rty(3, 3, 2, 0, 6'h18), 5'd2, 1'b0, 1'b1, 32'h0, 1'b0, "R9 bad function");
        wr(rty(2, 0, 1, 0, 6'h25), 1, 32'h5, "R9 r2 kept after bad function");

        // R11: idle cycle with a writing word on the bus
        issue(1'b0, ity(6'h08, 0, 2, 16'h0100), 5'd2, 1'b0, 1'b0, 32'h0, 1'b0, "R11 idle write word");
        issue(1'b0, 32'hFC00_0000, 5'd0, 1'b0, 1'b0, 32'h0, 1'b0, "R11 idle illegal word");
        wr(rty(2, 0, 1, 0, 6'h25), 1, 32'h5, "R11 r2 kept after idle");

        @(negedge clk);
        instr_valid = 1'b0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule